// File: doc/BRIEF.md
# Atomic Pin Drive/Float Unit

This unit controls sixty-four general-purpose pads, arranged as two groups of thirty-two. Every pad has an output-level bit and an output-enable (direction) bit. A single command names one pad. In one step it either enables the pad's driver (drive) or releases it to high impedance (float), and it also writes the pad's output-level bit. The new level comes from one of eight sources: a constant, a caller flag, the inverse of a caller flag, the inverse of the current level, or "leave the level alone".

Each command also returns the pad's input level as a flag pair. The level is captured before the command's own change can reach the pad. Output-level writes are visible to the command in the very next cycle. Direction writes retire one cycle later, so a back-to-back command still reads the earlier direction. Pads see level changes two clocks after a command and direction changes three clocks after it. Pad inputs pass through a three-register path before commands can sample them.

Top module: `pin_dirout_unit`

## Requirements
- R1: After reset every pad has output enable 0 and output level 0, and `res_valid` is 0.
- R2: `cmd_pin[5]` selects the group: 0 is pads 0..31 and 1 is pads 32..63. `cmd_pin[4:0]` selects the bit within the group, so the pad number equals `cmd_pin`. No other pad changes.
- R3: A command with `cmd_float`=1 clears the pad's enable. A command with `cmd_float`=0 sets it.
- R4: `cmd_src` picks the new level as follows: 0 gives 1, 1 gives 0, 2 gives `flag_c`, 3 gives NOT `flag_c`, 4 gives `flag_z`, 5 gives NOT `flag_z`, 6 gives NOT of the current level, and 7 leaves the level unchanged.
- R5: One cycle after an accepted command, `res_valid` is 1, `res_c` equals the sampled input level and `res_z` equals its inverse.
- R6: The sample is taken through three registers, so a pad change is first seen by a command accepted at the fourth rising edge after the change. A command accepted at the third edge still returns the old level.
- R7: A command accepted in the cycle right after another one sees that command's level write. For example, source 6 inverts the forwarded value.
- R8: `res_dir` returns the pad's enable as read by the command. The enable write of the command accepted one cycle earlier is not yet visible to it.
- R9: A level written while a pad floats is held. A later drive with source 7 drives that held level.
- R10: A level change appears on `pin_out` at the second rising edge after acceptance, and an enable change appears on `pin_oe` at the third.
- R11: While `cmd_valid` is 0, no pad level or enable changes, whatever the other command inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_float | input | 1 | 1 floats the pad, 0 drives it |
| cmd_src | input | 3 | Level source code |
| cmd_pin | input | 6 | Pad number (group bit and bit index) |
| flag_c | input | 1 | Caller carry flag |
| flag_z | input | 1 | Caller zero flag |
| pin_in | input | 64 | Raw pad input levels |
| pin_out | output | 64 | Pad output levels |
| pin_oe | output | 64 | Pad output enables |
| res_valid | output | 1 | Result strobe |
| res_c | output | 1 | Sampled input level |
| res_z | output | 1 | Inverse of the sampled input level |
| res_dir | output | 1 | Enable as seen by the command |

## Verification
The bench sweeps every pad through both actions and all eight sources, with random flags, and checks that only the named pad moves. Back-to-back commands target the forwarding corner. A design without level forwarding would invert a stale level, and a design that forwarded the enable would report the new direction instead of the old one. An input edge is placed exactly at the synchronizer boundary, so a design with one register too many or too few returns the wrong level. Pad latency is checked at the exact edge, and float-then-drive-keep exposes any design that cleared the held level when the pad was released.

// File: rtl/pin_unit_pkg.sv
package pin_unit_pkg;
  typedef enum logic [2:0] {
    SRC_HIGH = 3'd0,
    SRC_LOW  = 3'd1,
    SRC_C    = 3'd2,
    SRC_NC   = 3'd3,
    SRC_Z    = 3'd4,
    SRC_NZ   = 3'd5,
    SRC_INV  = 3'd6,
    SRC_KEEP = 3'd7
  } out_src_e;

  // New level for a pad given the source code, caller flags and current level.
  function automatic logic pick_level(out_src_e s, logic c, logic z, logic cur);
    case (s)
      SRC_HIGH: return 1'b1;
      SRC_LOW:  return 1'b0;
      SRC_C:    return c;
      SRC_NC:   return ~c;
      SRC_Z:    return z;
      SRC_NZ:   return ~z;
      SRC_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int W      = 64,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_out_pipe.sv
module pin_out_pipe #(
  parameter int W     = 64,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/pin_group_bank.sv
module pin_group_bank #(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_we,
  input  logic [IDX_W-1:0] lvl_idx,
  input  logic             lvl_val,
  input  logic             en_we,
  input  logic [IDX_W-1:0] en_idx,
  input  logic             en_val,
  output logic [W-1:0]     lvl_q,
  output logic [W-1:0]     en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= '0;
    end else begin
      if (lvl_we) lvl_q[lvl_idx] <= lvl_val;
      if (en_we)  en_q[en_idx]   <= en_val;
    end
  end

  assert_level_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> lvl_q[$past(lvl_idx)] == $past(lvl_val));
  assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q[$past(en_idx)] == $past(en_val));
  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_we |=> $stable(lvl_q));
  assert_idle_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/pin_dirout_unit.sv
module pin_dirout_unit
  import pin_unit_pkg::*;
#(
  parameter int GROUP_W    = 32,
  parameter int OUT_DEPTH  = 2,
  parameter int SYNC_DEPTH = 3,
  localparam int IDX_W  = $clog2(GROUP_W),
  localparam int PIN_W  = IDX_W + 1,
  localparam int BANK_W = 2 * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_float,
  input  logic [2:0]        cmd_src,
  input  logic [PIN_W-1:0]  cmd_pin,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic [BANK_W-1:0] pin_in,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe,
  output logic              res_valid,
  output logic              res_c,
  output logic              res_z,
  output logic              res_dir
);
  // Named internal events for assertions.
  logic [BANK_W-1:0] lvl_all, en_all, in_q;
  logic              cur_lvl, new_lvl, lvl_touch, in_sel, en_sel;
  out_src_e          src;

  // Enable write-back stage (retires one cycle after acceptance).
  logic             wb_valid, wb_set;
  logic [PIN_W-1:0] wb_pin;

  assign src       = out_src_e'(cmd_src);
  assign cur_lvl   = lvl_all[cmd_pin];
  assign new_lvl   = pick_level(src, flag_c, flag_z, cur_lvl);
  assign lvl_touch = cmd_valid && (src != SRC_KEEP);
  assign in_sel    = in_q[cmd_pin];
  assign en_sel    = en_all[cmd_pin];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [GROUP_W-1:0] lvl_g, en_g;
    pin_group_bank #(.W(GROUP_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_we  (lvl_touch && (cmd_pin[IDX_W] == 1'(g))),
      .lvl_idx (cmd_pin[IDX_W-1:0]),
      .lvl_val (new_lvl),
      .en_we   (wb_valid && (wb_pin[IDX_W] == 1'(g))),
      .en_idx  (wb_pin[IDX_W-1:0]),
      .en_val  (wb_set),
      .lvl_q   (lvl_g),
      .en_q    (en_g)
    );
    assign lvl_all[g*GROUP_W +: GROUP_W] = lvl_g;
    assign en_all[g*GROUP_W +: GROUP_W]  = en_g;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_set    <= 1'b0;
      wb_pin    <= '0;
      res_valid <= 1'b0;
      res_c     <= 1'b0;
      res_z     <= 1'b1;
      res_dir   <= 1'b0;
    end else begin
      wb_valid  <= cmd_valid;
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        wb_set  <= ~cmd_float;
        wb_pin  <= cmd_pin;
        res_c   <= in_sel;
        res_z   <= ~in_sel;
        res_dir <= en_sel;
      end
    end
  end

  pin_in_sync #(.W(BANK_W), .STAGES(SYNC_DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_q));
  pin_out_pipe #(.W(BANK_W), .DEPTH(OUT_DEPTH)) u_lvl_pipe (
    .clk(clk), .rst_n(rst_n), .d(lvl_all), .q(pin_out));
  pin_out_pipe #(.W(BANK_W), .DEPTH(OUT_DEPTH)) u_en_pipe (
    .clk(clk), .rst_n(rst_n), .d(en_all), .q(pin_oe));

  assert_result_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid));
  assert_flag_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_c != res_z));
  assert_sample_before_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_c == $past(in_sel));
  assert_stale_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_dir == $past(en_sel));
  assert_pad_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == $past(lvl_all, 2));
endmodule

// File: tb/pin_dirout_unit_tb.sv
`timescale 1ns/1ps
module pin_dirout_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_float = 1'b0, flag_c = 1'b0, flag_z = 1'b0;
  logic [2:0]  cmd_src = '0;
  logic [5:0]  cmd_pin = '0;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic        res_valid, res_c, res_z, res_dir;

  logic [63:0] out_m = '0, dir_m = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_dirout_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_float(cmd_float),
    .cmd_src(cmd_src), .cmd_pin(cmd_pin), .flag_c(flag_c), .flag_z(flag_z),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .res_valid(res_valid), .res_c(res_c), .res_z(res_z), .res_dir(res_dir));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic level_of(int s, logic c, logic z, logic cur);
    case (s)
      0: return 1'b1;
      1: return 1'b0;
      2: return c;
      3: return !c;
      4: return z;
      5: return !z;
      6: return !cur;
      default: return cur;
    endcase
  endfunction

  // Drive one command at the current negedge; update the model.
  task automatic issue(input int p, input bit fl, input int s, input bit c, input bit z);
    cmd_valid = 1; cmd_pin = 6'(p); cmd_float = fl; cmd_src = 3'(s);
    flag_c = c; flag_z = z;
    out_m[p] = level_of(s, c, z, out_m[p]);
    dir_m[p] = !fl;
  endtask

  task automatic do_cmd(input int p, input bit fl, input int s, input bit c, input bit z,
                        input bit exp_in);
    logic old_dir;
    old_dir = dir_m[p];
    issue(p, fl, s, c, z);
    @(negedge clk);
    cmd_valid = 0;
    chk(res_valid === 1'b1, "R5 res_valid", 64'(res_valid), 64'd1);
    chk(res_c === exp_in && res_z === !exp_in, "R5 res_c/res_z", {res_c, res_z}, {exp_in, !exp_in});
    chk(res_dir === old_dir, "R8 res_dir", 64'(res_dir), 64'(old_dir));
    repeat (3) @(negedge clk);
    chk(pin_out === out_m, "R2/R4 pin_out", pin_out, out_m);
    chk(pin_oe === dir_m, "R2/R3 pin_oe", pin_oe, dir_m);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pin_out === '0, "R1 pin_out", pin_out, '0);
    chk(pin_oe === '0, "R1 pin_oe", pin_oe, '0);
    chk(res_valid === 1'b0, "R1 res_valid", 64'(res_valid), 0);
    rst_n = 1;
    pin_in = {$urandom, $urandom};
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5: sweep all pads, both actions, all sources
    for (int p = 0; p < 64; p++)
      for (int fl = 0; fl < 2; fl++)
        for (int s = 0; s < 8; s++)
          do_cmd(p, fl[0], s, 1'($urandom), 1'($urandom), pin_in[p]);

    // R11: idle inputs wiggle, nothing changes
    for (int i = 0; i < 8; i++) begin
      cmd_pin = 6'($urandom); cmd_src = 3'($urandom); cmd_float = 1'($urandom);
      flag_c = 1'($urandom); flag_z = 1'($urandom);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(pin_out === out_m, "R11 pin_out idle", pin_out, out_m);
    chk(pin_oe === dir_m, "R11 pin_oe idle", pin_oe, dir_m);
    chk(res_valid === 1'b0, "R11 res_valid idle", 64'(res_valid), 0);

    // R10: exact pad latency on pad 40 (float low first)
    do_cmd(40, 1, 1, 0, 0, pin_in[40]);
    issue(40, 0, 0, 0, 0);
    @(negedge clk); cmd_valid = 0;
    @(negedge clk);
    chk(pin_out[40] === 1'b0, "R10 level not before edge 2", 64'(pin_out[40]), 0);
    @(negedge clk);
    chk(pin_out[40] === 1'b1, "R10 level at edge 2", 64'(pin_out[40]), 1);
    chk(pin_oe[40] === 1'b0, "R10 enable not before edge 3", 64'(pin_oe[40]), 0);
    @(negedge clk);
    chk(pin_oe[40] === 1'b1, "R10 enable at edge 3", 64'(pin_oe[40]), 1);

    // R9: float with high level held, then drive keep
    do_cmd(7, 1, 0, 0, 0, pin_in[7]);
    chk(pin_out[7] === 1'b1 && pin_oe[7] === 1'b0, "R9 held while floating",
        {pin_out[7], pin_oe[7]}, 2'b10);
    do_cmd(7, 0, 7, 0, 0, pin_in[7]);
    chk(pin_out[7] === 1'b1 && pin_oe[7] === 1'b1, "R9 drive keep",
        {pin_out[7], pin_oe[7]}, 2'b11);

    // R7 R8: back-to-back on pad 5 (start driven, low)
    do_cmd(5, 0, 1, 0, 0, pin_in[5]);
    issue(5, 1, 0, 0, 0);           // float, level high
    @(negedge clk);
    chk(res_dir === 1'b1, "R8 first res_dir", 64'(res_dir), 1);
    issue(5, 1, 6, 0, 0);           // float, invert forwarded level
    @(negedge clk); cmd_valid = 0;
    chk(res_dir === 1'b1, "R8 stale enable back-to-back", 64'(res_dir), 1);
    repeat (3) @(negedge clk);
    chk(pin_out[5] === 1'b0, "R7 forwarded invert", 64'(pin_out[5]), 0);
    chk(pin_oe === dir_m, "R8 enables retire", pin_oe, dir_m);

    // R6: input edge at synchronizer boundary on pad 50
    begin
      logic old_v;
      old_v = pin_in[50];
      pin_in[50] = !old_v;
      repeat (2) @(negedge clk);
      do_cmd(50, 0, 7, 0, 0, old_v);      // accepted at 3rd edge: old
      do_cmd(50, 0, 7, 0, 0, !old_v);     // later: new
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule